// File: doc/BRIEF.md
# Page-Buffered Write Cycle Controller

This block sits behind a serial-bus target front end of a multi-bank byte memory. While a write transaction is running it gathers the incoming data bytes into a small page buffer. It does not touch the array until the bus signals STOP. At STOP it enters a timed internal programming cycle. During that cycle it issues one array write strobe for each page slot that actually received a byte. It holds a busy flag for the whole cycle, and the front end uses that flag to refuse acknowledges, so a host can poll for completion.

A transaction opens with a one-cycle `begin_i` pulse. The pulse carries the starting word address and a bank select. Bank select 0 names no bank and is ignored. Data bytes arrive on a valid/ready stream. `byte_ready_o` drops only while the internal cycle runs, and a byte is transferred on any cycle where valid and ready are both high. Bytes transferred outside an open transaction are discarded. Within a transaction only the low address bits that index the page advance, so extra bytes wrap and overwrite earlier slots of the same page.

A write-enable level and a low-supply flag guard the array. If either one is bad while bytes are being loaded, nothing is programmed. If either one goes bad during the internal cycle, the cycle stops at once and an abort pulse is raised. When a cycle completes, the address of the last byte received is handed back so that a following current read starts there.

Top module: `pgw_commit`

## Requirements
- R1: After reset, `busy_o`, `wr_en_o`, `abort_o` and `hand_valid_o` are 0 and `byte_ready_o` is 1.
- R2: `byte_ready_o` is 0 exactly while `busy_o` is 1. A byte transferred while no transaction is open changes nothing that is later programmed.
- R3: The slot for each accepted byte is the low log2(PAGE_BYTES) bits of the start address plus the byte index, modulo PAGE_BYTES. The upper address bits stay fixed. A later byte that maps to a slot already filled replaces it.
- R4: Only a STOP ends loading with a commit. A new `begin_i` before STOP discards everything gathered so far, and if STOP never comes, no write strobe is issued.
- R5: During the cycle each received slot is written exactly once, in ascending slot order, one strobe per clock. Slots that received no byte are not written, so those array locations keep their contents.
- R6: `busy_o` stays high for exactly WR_CLKS clocks after the STOP edge. While busy, `begin_i`, bytes and STOP have no effect.
- R7: If the write-enable input `wp_i` is 0 on any cycle from `begin_i` through STOP, the STOP starts no cycle.
- R8: If `wp_i` is 0 or `lowv_i` is 1 during the cycle, `abort_o` pulses for one clock and `busy_o` falls on the same edge. No further strobes are issued.
- R9: If `lowv_i` is 1 on any cycle from `begin_i` through STOP, the STOP starts no cycle.
- R10: A `begin_i` with bank select 0 opens no transaction.
- R11: When a cycle completes without abort, `hand_valid_o` pulses for one clock. The pulse carries the address of the last byte received (upper bits, then that byte's slot) and the bank.
- R12: A STOP after a transaction that received no bytes starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| begin_i | input | 1 | Opens a write transaction (one-cycle pulse) |
| start_addr_i | input | ADDR_W | First word address of the transaction |
| bank_i | input | BANK_W | Bank select, 0 = none |
| byte_valid_i | input | 1 | Data byte offered |
| byte_ready_o | output | 1 | Data byte can be taken |
| byte_data_i | input | DATA_W | Data byte |
| stop_i | input | 1 | Bus STOP seen (one-cycle pulse) |
| wp_i | input | 1 | Write enable level, 1 = writes allowed |
| lowv_i | input | 1 | Supply too low for programming |
| busy_o | output | 1 | Internal cycle in progress; front end must not acknowledge |
| wr_en_o | output | 1 | Array write strobe |
| wr_bank_o | output | BANK_W | Bank of the write |
| wr_addr_o | output | ADDR_W | Word address of the write |
| wr_data_o | output | DATA_W | Data of the write |
| abort_o | output | 1 | Cycle cut short by a bad write-enable or supply |
| hand_valid_o | output | 1 | Completed cycle; hand-back address valid |
| hand_addr_o | output | ADDR_W | Address of the last byte received |
| hand_bank_o | output | BANK_W | Bank of the completed cycle |

## Verification
The embedded properties check several rules on every cycle: the fixed upper address bits and bank during a cycle, that a cycle starts only on STOP, the abort and hand-back pulse relations, the clearing of the buffer when a transaction opens, and the steady advance of the cycle timer. Other behaviour only shows up in the bench scenarios: which array locations end up holding which bytes after page wrap, that a partially filled page leaves its other locations intact, the exact busy length, the hand-back value, and the cases where STOP, bank 0, write-enable or supply suppress a cycle. The sweep runs every start slot against byte counts from one to past a full page.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } pgw_state_e;
endpackage

// File: rtl/pgw_page_buf.sv
// Page staging store: one data register and one filled flag per slot.
module pgw_page_buf #(
  parameter int PAGE_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int SLOT_W    = $clog2(PAGE_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr_i,
  input  logic                  wr_i,
  input  logic [SLOT_W-1:0]     wslot_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [SLOT_W-1:0]     rslot_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [PAGE_BYTES-1:0] mask_o
);
  logic [PAGE_BYTES*DATA_W-1:0] flat;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [DATA_W-1:0] q;
    logic              v;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
        v <= 1'b0;
      end else if (clr_i) begin
        v <= 1'b0;              // opening a transaction wins over a byte
      end else if (wr_i && wslot_i == SLOT_W'(g)) begin
        q <= wdata_i;
        v <= 1'b1;
      end
    end
    assign flat[g*DATA_W +: DATA_W] = q;
    assign mask_o[g] = v;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < PAGE_BYTES; i++)
      if (rslot_i == SLOT_W'(i)) rdata_o = flat[i*DATA_W +: DATA_W];
  end

  // R4: a new transaction starts from an empty page
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_i) |-> mask_o == '0);
endmodule

// File: rtl/pgw_wr_timer.sv
// Counts the clocks of the internal programming cycle.
module pgw_wr_timer #(
  parameter int CLKS = 500,
  localparam int CNT_W = $clog2(CLKS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic done_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (run_i) cnt <= cnt + 1'b1;
    else            cnt <= '0;
  end

  assign done_o = run_i && (cnt == CNT_W'(CLKS - 1));

  // R6: the cycle timer advances by one on every running clock
  p_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && $past(run_i) |-> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/pgw_commit.sv
// Page-buffered write cycle controller. WR_CLKS must be at least PAGE_BYTES.
module pgw_commit
  import pgw_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 2,
  parameter int WR_CLKS    = 500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              begin_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              stop_i,
  input  logic              wp_i,
  input  logic              lowv_i,
  output logic              busy_o,
  output logic              wr_en_o,
  output logic [BANK_W-1:0] wr_bank_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              abort_o,
  output logic              hand_valid_o,
  output logic [ADDR_W-1:0] hand_addr_o,
  output logic [BANK_W-1:0] hand_bank_o
);
  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - SLOT_W;

  pgw_state_e            state;
  logic [HI_W-1:0]       base_hi;
  logic [SLOT_W-1:0]     ptr;
  logic [SLOT_W-1:0]     last_slot;
  logic [BANK_W-1:0]     bank_q;
  logic                  spoiled;
  logic [SLOT_W:0]       scan;     // top bit set once every slot is visited
  logic [PAGE_BYTES-1:0] mask;
  logic [DATA_W-1:0]     rdata;
  logic                  accept, begin_ok, spoil_now, t_done;

  assign spoil_now    = !wp_i || lowv_i;
  assign byte_ready_o = (state != ST_PROG);
  assign busy_o       = (state == ST_PROG);
  assign accept       = byte_valid_i && (state == ST_LOAD);
  assign begin_ok     = begin_i && (state != ST_PROG) && (bank_i != '0);
  assign last_slot    = ptr - 1'b1;

  pgw_page_buf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) buf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (begin_ok),
    .wr_i    (accept),
    .wslot_i (ptr),
    .wdata_i (byte_data_i),
    .rslot_i (scan[SLOT_W-1:0]),
    .rdata_o (rdata),
    .mask_o  (mask)
  );

  pgw_wr_timer #(.CLKS(WR_CLKS)) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_o),
    .done_o (t_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      base_hi      <= '0;
      ptr          <= '0;
      bank_q       <= '0;
      spoiled      <= 1'b0;
      scan         <= '0;
      abort_o      <= 1'b0;
      hand_valid_o <= 1'b0;
      hand_addr_o  <= '0;
      hand_bank_o  <= '0;
    end else begin
      abort_o      <= 1'b0;
      hand_valid_o <= 1'b0;
      if (state == ST_PROG) begin
        if (!scan[SLOT_W]) scan <= scan + 1'b1;
        if (spoil_now) begin
          abort_o <= 1'b1;
          state   <= ST_IDLE;
        end else if (t_done) begin
          hand_valid_o <= 1'b1;
          hand_addr_o  <= {base_hi, last_slot};
          hand_bank_o  <= bank_q;
          state        <= ST_IDLE;
        end
      end else if (begin_ok) begin
        state   <= ST_LOAD;
        base_hi <= start_addr_i[ADDR_W-1:SLOT_W];
        ptr     <= start_addr_i[SLOT_W-1:0];
        bank_q  <= bank_i;
        spoiled <= spoil_now;
      end else if (state == ST_LOAD) begin
        if (accept) ptr <= ptr + 1'b1;
        if (stop_i) begin
          if ((|mask || accept) && !spoiled && !spoil_now) begin
            state <= ST_PROG;
            scan  <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end else if (spoil_now) begin
          spoiled <= 1'b1;
        end
      end
    end
  end

  assign wr_en_o   = busy_o && !scan[SLOT_W] && mask[scan[SLOT_W-1:0]];
  assign wr_bank_o = bank_q;
  assign wr_addr_o = {base_hi, scan[SLOT_W-1:0]};
  assign wr_data_o = rdata;

  // R3: page-upper address bits never move during a cycle
  p_hi_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(wr_addr_o[ADDR_W-1:SLOT_W]));
  // R6: commands arriving while busy cannot retarget the bank
  p_bank_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(wr_bank_o));
  // R4: a cycle begins only on a STOP
  p_start_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));
  // R8: abort ends the cycle and follows a bad enable or supply
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !busy_o && $past(busy_o) && (!$past(wp_i) || $past(lowv_i)));
  // R11: hand-back only on a normal completion
  p_hand_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hand_valid_o |-> !busy_o && $past(busy_o) && !abort_o);
endmodule

// File: tb/pgw_commit_tb.sv
`timescale 1ns/1ps
module pgw_commit_tb_top;
  localparam int WR_CLKS = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       begin_i = 1'b0, byte_valid_i = 1'b0, stop_i = 1'b0;
  logic       wp_i = 1'b1, lowv_i = 1'b0;
  logic [7:0] start_addr_i = '0, byte_data_i = '0;
  logic [1:0] bank_i = '0;
  logic       byte_ready_o, busy_o, wr_en_o, abort_o, hand_valid_o;
  logic [1:0] wr_bank_o, hand_bank_o;
  logic [7:0] wr_addr_o, wr_data_o, hand_addr_o;

  always #5 clk = ~clk;

  pgw_commit #(.PAGE_BYTES(8), .ADDR_W(8), .DATA_W(8), .BANK_W(2),
               .WR_CLKS(WR_CLKS)) dut_i (.*);

  logic [7:0] cells [4][256];
  logic [7:0] expc  [4][256];
  int wr_cnt, busy_cnt, abort_cnt, hand_cnt, ord_err, prev_slot;
  logic [7:0] hand_a;
  logic [1:0] hand_b;
  int total = 0, fails = 0;

  always @(negedge clk) if (rst_n) begin
    if (wr_en_o) begin
      cells[wr_bank_o][wr_addr_o] = wr_data_o;
      if (int'(wr_addr_o[2:0]) <= prev_slot) ord_err++;
      prev_slot = int'(wr_addr_o[2:0]);
      wr_cnt++;
    end
    if (busy_o) busy_cnt++;
    if (abort_o) abort_cnt++;
    if (hand_valid_o) begin hand_cnt++; hand_a = hand_addr_o; hand_b = hand_bank_o; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic clr_mon();
    wr_cnt = 0; busy_cnt = 0; abort_cnt = 0; hand_cnt = 0; ord_err = 0; prev_slot = -1;
  endtask
  task automatic do_begin(input logic [1:0] b, input logic [7:0] a);
    begin_i = 1'b1; bank_i = b; start_addr_i = a; tick(); begin_i = 1'b0;
  endtask
  task automatic send(input logic [7:0] d);
    byte_valid_i = 1'b1; byte_data_i = d; tick(); byte_valid_i = 1'b0;
  endtask
  task automatic do_stop(); stop_i = 1'b1; tick(); stop_i = 1'b0; endtask
  task automatic settle(); repeat (WR_CLKS + 6) tick(); endtask

  function automatic int mism();
    int m = 0;
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 256; a++) if (cells[b][a] !== expc[b][a]) m++;
    return m;
  endfunction

  initial begin
    #2_000_000;
    fails++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int a = 0; a < 256; a++) begin cells[b][a] = 8'hFF; expc[b][a] = 8'hFF; end
    clr_mon();
    repeat (3) tick();
    // R1: reset values
    chk(busy_o == 0 && wr_en_o == 0 && abort_o == 0 && hand_valid_o == 0, "R1 reset outputs", int'(busy_o), 0);
    chk(byte_ready_o == 1, "R1 ready in reset", int'(byte_ready_o), 1);
    rst_n = 1'b1;
    tick();
    chk(byte_ready_o == 1 && busy_o == 0, "R1 ready after reset", int'(byte_ready_o), 1);

    // R3 R5 R6 R11: sweep start slot and byte count
    for (int s = 0; s < 8; s++)
      for (int n = 1; n <= 10; n++) begin
        logic [1:0] b;
        logic [7:0] base;
        int ehand;
        b = 2'(1 + (s + n) % 3);
        base = 8'((s * 37 + n * 11) & 8'hF8);
        clr_mon();
        do_begin(b, base | 8'(s));
        for (int i = 0; i < n; i++) begin
          logic [7:0] d;
          d = 8'(((s << 4) ^ (n * 29) ^ (i * 53)) & 8'hFF);
          expc[b][base | 8'((s + i) % 8)] = d;
          send(d);
        end
        do_stop();
        settle();
        ehand = int'(base) | ((s + n - 1) % 8);
        chk(mism() == 0, "R3 array contents after page wrap", mism(), 0);
        chk(wr_cnt == (n < 8 ? n : 8), "R5 strobe count", wr_cnt, (n < 8 ? n : 8));
        chk(ord_err == 0, "R5 ascending slot order", ord_err, 0);
        chk(busy_cnt == WR_CLKS, "R6 busy length", busy_cnt, WR_CLKS);
        chk(hand_cnt == 1 && int'(hand_a) == ehand && hand_b == b, "R11 hand-back address", int'(hand_a), ehand);
      end

    // R10: bank 0 opens nothing
    clr_mon();
    do_begin(2'd0, 8'h40); send(8'h12); do_stop(); settle();
    chk(busy_cnt == 0 && wr_cnt == 0, "R10 bank zero ignored", wr_cnt, 0);

    // R12 and R2: idle bytes dropped, empty transaction starts nothing
    clr_mon();
    send(8'h99); send(8'h98);
    do_begin(2'd1, 8'h50); do_stop(); settle();
    chk(busy_cnt == 0 && wr_cnt == 0, "R12 empty transaction", busy_cnt, 0);
    chk(mism() == 0, "R2 idle bytes ignored", mism(), 0);

    // R4: no STOP then reopen; only the second transaction commits
    clr_mon();
    do_begin(2'd2, 8'h60); send(8'hA1); send(8'hA2); settle();
    chk(busy_cnt == 0 && wr_cnt == 0, "R4 no stop no write", wr_cnt, 0);
    do_begin(2'd2, 8'h70); send(8'hB1); expc[2][8'h70] = 8'hB1; do_stop(); settle();
    chk(wr_cnt == 1 && mism() == 0, "R4 reopen discards earlier bytes", wr_cnt, 1);

    // R7: enable dropped during loading
    clr_mon();
    do_begin(2'd3, 8'h80); send(8'hC1); wp_i = 1'b0; tick(); wp_i = 1'b1; send(8'hC2); do_stop(); settle();
    chk(busy_cnt == 0 && wr_cnt == 0 && mism() == 0, "R7 enable low while loading", wr_cnt, 0);

    // R9: low supply at STOP
    clr_mon();
    do_begin(2'd1, 8'h88); send(8'hD1); lowv_i = 1'b1; do_stop(); lowv_i = 1'b0; settle();
    chk(busy_cnt == 0 && wr_cnt == 0 && mism() == 0, "R9 low supply blocks", wr_cnt, 0);

    // R8: enable dropped after three strobes
    clr_mon();
    do_begin(2'd1, 8'h90);
    for (int i = 0; i < 8; i++) send(8'(8'hE0 + i));
    for (int i = 0; i < 3; i++) expc[1][8'h90 + 8'(i)] = 8'(8'hE0 + i);
    do_stop(); tick(); tick();
    wp_i = 1'b0; tick(); wp_i = 1'b1; settle();
    chk(abort_cnt == 1 && hand_cnt == 0, "R8 abort pulse", abort_cnt, 1);
    chk(wr_cnt == 3 && busy_cnt == 3, "R8 strobes stop at abort", wr_cnt, 3);
    chk(mism() == 0, "R8 array after abort", mism(), 0);

    // R8: low supply during the cycle
    clr_mon();
    do_begin(2'd3, 8'hA0); send(8'h11); send(8'h22); expc[3][8'hA0] = 8'h11; expc[3][8'hA1] = 8'h22;
    do_stop(); repeat (10) tick();
    lowv_i = 1'b1; tick(); lowv_i = 1'b0; settle();
    chk(abort_cnt == 1 && busy_cnt == 11 && mism() == 0, "R8 low supply aborts", busy_cnt, 11);

    // R6 R2: commands during busy ignored, ready low
    clr_mon();
    do_begin(2'd2, 8'hB3); send(8'h5A); expc[2][8'hB3] = 8'h5A; do_stop();
    tick();
    chk(byte_ready_o == 0, "R2 ready low while busy", int'(byte_ready_o), 0);
    do_begin(2'd1, 8'hC0); send(8'h77); do_stop();
    settle();
    chk(busy_cnt == WR_CLKS && wr_cnt == 1, "R6 polling commands ignored", busy_cnt, WR_CLKS);
    chk(mism() == 0 && hand_a == 8'hB3, "R6 array after polling", int'(hand_a), 8'hB3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule